// File: doc/BRIEF.md
# Warp Issue Scheduler with Register Scoreboard

This block makes the issue decision for one execution sub-partition that holds several resident warps. Each warp shows its next two instructions as packed words. Each word carries a valid flag, an operation kind, a destination register and two source registers. In every cycle the block sorts the allocated warps into stalled and eligible. It then grants one eligible warp under rotating priority and issues either one instruction or a pair of consecutive instructions from that warp. The issue decision is combinational and takes effect in the same cycle. Moving from one warp to another costs no cycles.

The block keeps a per-warp scoreboard with one pending bit for each register. An arithmetic result clears its bit after a fixed dependent latency. A load result clears its bit only when the completion port reports it, which can take any number of cycles. A warp can keep issuing independent work after a load and stalls only when an instruction needs the pending register. A warp that issues an exit instruction never issues again. It is reported done once all of its pending results have returned.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst_n` is low and after it is released, no scoreboard bit is set, no warp has exited and `warp_done` is zero. Warp 0 has the highest priority at the first issue after reset.
- R2: An instruction word is packed as follows: bit 14 = valid, bits 13:12 = kind (0 arithmetic, 1 load, 2 exit, 3 arithmetic), bits 11:8 = destination, bits 7:4 = source A, bits 3:0 = source B. `warp_eligible[w]` is high only when all of these hold: warp w is active, it has not exited, its first word is valid, and for a non-exit kind none of the two sources or the destination is pending. An inactive warp never issues.
- R3: The granted warp is the first eligible warp found by counting upward from the warp issued last, wrapping around.
- R4: `issue_dual` is high only when all of these hold: the second word is valid, neither word is an exit, the second word's sources and destination are not pending, and the second word neither reads nor writes the first word's destination.
- R5: An instruction that depends on an arithmetic result issued in cycle c stays stalled in cycles c+1 to c+5 and can issue in cycle c+6.
- R6: After a load issues, independent instructions from the same warp keep issuing. An instruction that reads the load's destination stalls until a completion for that warp and register is sampled, and it can issue in the following cycle.
- R7: A completion that names a register not pending for that warp changes nothing.
- R8: After an exit issues, the warp never issues again. `warp_done` for that warp rises in the cycle after the last of its pending bits clears, or in the cycle after the exit if none are pending, and it stays high.
- R9: When no warp is eligible, `issue_valid` is low and the rotating priority keeps its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| warp_active | input | NUM_WARPS | Warp is allocated with all its resources |
| slot0_word | input | NUM_WARPS*IW | Next instruction of each warp, warp w at bits w*IW upward |
| slot1_word | input | NUM_WARPS*IW | Instruction after it, same packing |
| ld_done_valid | input | 1 | A load result has returned |
| ld_done_warp | input | WW | Warp of the returned load |
| ld_done_reg | input | RW | Destination register of the returned load |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WW | Warp that issues |
| issue_dual | output | 1 | The second word issues too |
| warp_eligible | output | NUM_WARPS | Per-warp eligible mask |
| warp_done | output | NUM_WARPS | Warp has exited and drained |

## Verification
A pending bit that is wrongly left set holds a warp at `issue_valid` low for longer than the required wait, and a bit cleared too early lets a dependent instruction issue in cycle c+5 or before its load has returned. Both errors appear at the ports within one cycle of the expected release. A wrong priority pointer shows as the wrong `issue_warp` on the very next grant. A wrong exit or drain state shows as an early, late or missing `warp_done`, or as an issue after exit, in the cycle that follows.

// File: rtl/sched_pkg.sv
// Shared operation kinds and helpers for the warp issue scheduler.
// Assumes the kind field of an instruction word is two bits wide.
package sched_pkg;

    typedef enum logic [1:0] {
        OP_ALU     = 2'd0,
        OP_LOAD    = 2'd1,
        OP_EXIT    = 2'd2,
        OP_ALU_ALT = 2'd3
    } op_kind_e;

    // True for kinds whose result returns after the fixed arithmetic latency.
    function automatic logic is_fixed_lat(input op_kind_e k);
        return (k == OP_ALU) || (k == OP_ALU_ALT);
    endfunction

endpackage

// File: rtl/sched_scoreboard.sv
// Per-warp register scoreboard.
// Two issue lanes set pending bits. Fixed-latency results are carried along a
// delay line and clear their bit ALU_LAT-1 edges after they were set, so a
// dependant issues exactly ALU_LAT cycles after its producer. The load
// completion port clears any bit it names; a set wins over a clear that lands
// on the same edge.
// Assumes ALU_LAT >= 2 and NUM_REGS a power of two.
module sched_scoreboard #(
    parameter int NUM_WARPS = 4,
    parameter int NUM_REGS  = 16,
    parameter int ALU_LAT   = 6,
    localparam int WW = $clog2(NUM_WARPS),
    localparam int RW = $clog2(NUM_REGS),
    localparam int SB = NUM_WARPS * NUM_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_a_en,
    input  logic [WW-1:0] set_a_warp,
    input  logic [RW-1:0] set_a_reg,
    input  logic          set_a_fixed,
    input  logic          set_b_en,
    input  logic [WW-1:0] set_b_warp,
    input  logic [RW-1:0] set_b_reg,
    input  logic          set_b_fixed,
    input  logic          ld_done_valid,
    input  logic [WW-1:0] ld_done_warp,
    input  logic [RW-1:0] ld_done_reg,
    output logic [SB-1:0] pending
);

    localparam int DEPTH = ALU_LAT - 1;

    logic [DEPTH-1:0] dla_v, dlb_v;
    logic [WW-1:0]    dla_w [DEPTH];
    logic [WW-1:0]    dlb_w [DEPTH];
    logic [RW-1:0]    dla_r [DEPTH];
    logic [RW-1:0]    dlb_r [DEPTH];
    logic [SB-1:0]    set_mask, clr_mask;

    function automatic int sb_idx(input logic [WW-1:0] w, input logic [RW-1:0] r);
        return int'(w) * NUM_REGS + int'(r);
    endfunction

    // Delay line for fixed-latency results, one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dla_v <= '0;
            dlb_v <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                dla_w[s] <= '0;
                dlb_w[s] <= '0;
                dla_r[s] <= '0;
                dlb_r[s] <= '0;
            end
        end else begin
            dla_v[0] <= set_a_en && set_a_fixed;
            dla_w[0] <= set_a_warp;
            dla_r[0] <= set_a_reg;
            dlb_v[0] <= set_b_en && set_b_fixed;
            dlb_w[0] <= set_b_warp;
            dlb_r[0] <= set_b_reg;
            for (int s = 1; s < DEPTH; s++) begin
                dla_v[s] <= dla_v[s-1];
                dla_w[s] <= dla_w[s-1];
                dla_r[s] <= dla_r[s-1];
                dlb_v[s] <= dlb_v[s-1];
                dlb_w[s] <= dlb_w[s-1];
                dlb_r[s] <= dlb_r[s-1];
            end
        end
    end

    // Bits raised by the instructions issuing this cycle.
    always_comb begin
        set_mask = '0;
        if (set_a_en) set_mask[sb_idx(set_a_warp, set_a_reg)] = 1'b1;
        if (set_b_en) set_mask[sb_idx(set_b_warp, set_b_reg)] = 1'b1;
    end

    // Bits released by expiring arithmetic results and by load completions.
    always_comb begin
        clr_mask = '0;
        if (dla_v[DEPTH-1]) clr_mask[sb_idx(dla_w[DEPTH-1], dla_r[DEPTH-1])] = 1'b1;
        if (dlb_v[DEPTH-1]) clr_mask[sb_idx(dlb_w[DEPTH-1], dlb_r[DEPTH-1])] = 1'b1;
        if (ld_done_valid)  clr_mask[sb_idx(ld_done_warp, ld_done_reg)]     = 1'b1;
    end

    // Pending-bit state; a new set takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~clr_mask) | set_mask;
    end

endmodule

// File: rtl/sched_hazard.sv
// Per-warp hazard check.
// Decodes both presented words of every warp against that warp's pending bits
// and produces the eligible mask and a per-warp "second word may pair" flag.
// An exit reads and writes nothing. The pair flag is meaningful only for the
// granted warp.
module sched_hazard
    import sched_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int NUM_REGS  = 16,
    localparam int RW = $clog2(NUM_REGS),
    localparam int IW = 3 + 3 * RW,
    localparam int SB = NUM_WARPS * NUM_REGS
) (
    input  logic [NUM_WARPS-1:0]    warp_active,
    input  logic [NUM_WARPS-1:0]    warp_exited,
    input  logic [NUM_WARPS*IW-1:0] slot0_word,
    input  logic [NUM_WARPS*IW-1:0] slot1_word,
    input  logic [SB-1:0]           pending,
    output logic [NUM_WARPS-1:0]    warp_eligible,
    output logic [NUM_WARPS-1:0]    dual_ok
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic                v0, v1;
        logic [1:0]          k0_raw, k1_raw;
        op_kind_e            k0, k1;
        logic [RW-1:0]       d0, a0, b0, d1, a1, b1;
        logic [NUM_REGS-1:0] pw;
        logic                ready0, ready1, indep1;

        assign {v0, k0_raw, d0, a0, b0} = slot0_word[w*IW +: IW];
        assign {v1, k1_raw, d1, a1, b1} = slot1_word[w*IW +: IW];
        assign k0 = op_kind_e'(k0_raw);
        assign k1 = op_kind_e'(k1_raw);
        assign pw = pending[w*NUM_REGS +: NUM_REGS];

        assign ready0 = !pw[a0] && !pw[b0] && !pw[d0];
        assign ready1 = !pw[a1] && !pw[b1] && !pw[d1];
        assign indep1 = (a1 != d0) && (b1 != d0) && (d1 != d0);

        assign warp_eligible[w] = warp_active[w] && !warp_exited[w] && v0
                                  && ((k0 == OP_EXIT) || ready0);
        assign dual_ok[w] = v1 && (k0 != OP_EXIT) && (k1 != OP_EXIT)
                            && ready1 && indep1;
    end

endmodule

// File: rtl/sched_rr_pick.sv
// Rotating-priority picker.
// Grants the first requester above the previously granted index, wrapping,
// and remembers the grant. With no requester the pointer holds. After reset
// the pointer sits on the top index so index 0 is favoured first.
module sched_rr_pick #(
    parameter int NUM_WARPS = 4,
    localparam int WW = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] req,
    output logic                 grant_valid,
    output logic [WW-1:0]        grant_idx
);

    logic [WW-1:0] last_q;
    int            cand;

    // Search upward from the last grant for the first requester.
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        cand        = 0;
        for (int off = 1; off <= NUM_WARPS; off++) begin
            cand = (int'(last_q) + off) % NUM_WARPS;
            if (!grant_valid && req[cand]) begin
                grant_valid = 1'b1;
                grant_idx   = WW'(cand);
            end
        end
    end

    // Record the granted index as the new lowest-priority position.
    always_ff @(posedge clk) begin
        if (!rst_n)           last_q <= WW'(NUM_WARPS - 1);
        else if (grant_valid) last_q <= grant_idx;
    end

endmodule

// File: rtl/warp_issue_sched.sv
// Warp issue scheduler for one sub-partition.
// Each cycle: classify warps, grant one by rotating priority, issue one word
// or a pair from it, and record destinations in the scoreboard. Exit marks a
// warp as retired; it reports done once its pending bits have drained.
// Assumes NUM_WARPS >= 2 and NUM_REGS a power of two; the caller advances a
// warp's words by the count issued.
module warp_issue_sched
    import sched_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int NUM_REGS  = 16,
    parameter int ALU_LAT   = 6,
    localparam int WW = $clog2(NUM_WARPS),
    localparam int RW = $clog2(NUM_REGS),
    localparam int IW = 3 + 3 * RW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_WARPS-1:0]    warp_active,
    input  logic [NUM_WARPS*IW-1:0] slot0_word,
    input  logic [NUM_WARPS*IW-1:0] slot1_word,
    input  logic                    ld_done_valid,
    input  logic [WW-1:0]           ld_done_warp,
    input  logic [RW-1:0]           ld_done_reg,
    output logic                    issue_valid,
    output logic [WW-1:0]           issue_warp,
    output logic                    issue_dual,
    output logic [NUM_WARPS-1:0]    warp_eligible,
    output logic [NUM_WARPS-1:0]    warp_done
);

    localparam int SB = NUM_WARPS * NUM_REGS;

    logic [SB-1:0]        pending;
    logic [NUM_WARPS-1:0] exited_q;
    logic [NUM_WARPS-1:0] dual_ok;
    logic [1:0]           g_k0_raw, g_k1_raw;
    op_kind_e             g_k0, g_k1;
    logic [RW-1:0]        g_d0, g_d1;
    int                   g_base;

    sched_hazard #(
        .NUM_WARPS(NUM_WARPS),
        .NUM_REGS (NUM_REGS)
    ) u_hazard (
        .warp_active  (warp_active),
        .warp_exited  (exited_q),
        .slot0_word   (slot0_word),
        .slot1_word   (slot1_word),
        .pending      (pending),
        .warp_eligible(warp_eligible),
        .dual_ok      (dual_ok)
    );

    sched_rr_pick #(
        .NUM_WARPS(NUM_WARPS)
    ) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (warp_eligible),
        .grant_valid(issue_valid),
        .grant_idx  (issue_warp)
    );

    // Kind and destination of the granted warp's two words.
    assign g_base   = int'(issue_warp) * IW;
    assign g_k0_raw = slot0_word[g_base + 3*RW +: 2];
    assign g_k1_raw = slot1_word[g_base + 3*RW +: 2];
    assign g_d0     = slot0_word[g_base + 2*RW +: RW];
    assign g_d1     = slot1_word[g_base + 2*RW +: RW];
    assign g_k0     = op_kind_e'(g_k0_raw);
    assign g_k1     = op_kind_e'(g_k1_raw);

    assign issue_dual = issue_valid && dual_ok[issue_warp];

    sched_scoreboard #(
        .NUM_WARPS(NUM_WARPS),
        .NUM_REGS (NUM_REGS),
        .ALU_LAT  (ALU_LAT)
    ) u_sb (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_a_en     (issue_valid && (g_k0 != OP_EXIT)),
        .set_a_warp   (issue_warp),
        .set_a_reg    (g_d0),
        .set_a_fixed  (is_fixed_lat(g_k0)),
        .set_b_en     (issue_dual),
        .set_b_warp   (issue_warp),
        .set_b_reg    (g_d1),
        .set_b_fixed  (is_fixed_lat(g_k1)),
        .ld_done_valid(ld_done_valid),
        .ld_done_warp (ld_done_warp),
        .ld_done_reg  (ld_done_reg),
        .pending      (pending)
    );

    // Retire a warp when its exit word issues; the flag holds until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exited_q <= '0;
        end else if (issue_valid && (g_k0 == OP_EXIT)) begin
            exited_q[issue_warp] <= 1'b1;
        end
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_done
        assign warp_done[w] = exited_q[w] && !(|pending[w*NUM_REGS +: NUM_REGS]);
    end

endmodule

// File: rtl/sched_checker.sv
// Port-level properties of the warp issue scheduler, bound to its top.
module sched_checker #(
    parameter int NUM_WARPS = 4,
    localparam int WW = $clog2(NUM_WARPS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_WARPS-1:0] warp_active,
    input logic [NUM_WARPS-1:0] warp_eligible,
    input logic [NUM_WARPS-1:0] warp_done,
    input logic                 issue_valid,
    input logic [WW-1:0]        issue_warp,
    input logic                 issue_dual
);

    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> warp_eligible[issue_warp])
        else $error("granted warp not eligible");

    assert_grant_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> warp_active[issue_warp])
        else $error("granted warp not active");

    assert_eligible_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_eligible & ~warp_active) == '0)
        else $error("inactive warp marked eligible");

    assert_pair_needs_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_dual |-> issue_valid)
        else $error("pair without issue");

    assert_work_conserving_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|warp_eligible) |-> issue_valid)
        else $error("eligible warp left idle");

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> warp_done == '0)
        else $error("done raised out of reset");

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
        assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            warp_done[w] |=> warp_done[w])
            else $error("done dropped");

        assert_no_issue_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
            warp_done[w] |-> !(issue_valid && issue_warp == WW'(w)))
            else $error("retired warp issued");
    end

endmodule

bind warp_issue_sched sched_checker #(.NUM_WARPS(NUM_WARPS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .warp_active  (warp_active),
    .warp_eligible(warp_eligible),
    .warp_done    (warp_done),
    .issue_valid  (issue_valid),
    .issue_warp   (issue_warp),
    .issue_dual   (issue_dual)
);

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;

    localparam int W  = 4;
    localparam int IW = 15;
    localparam logic [1:0] K_ALU = 2'd0, K_LD = 2'd1, K_EXIT = 2'd2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  active = '0;
    logic [W*IW-1:0] s0 = '0, s1 = '0;
    logic          ldv = 1'b0;
    logic [1:0]    ldw = '0;
    logic [3:0]    ldr = '0;
    logic          issue_valid, issue_dual;
    logic [1:0]    issue_warp;
    logic [W-1:0]  warp_eligible, warp_done;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    warp_issue_sched dut (
        .clk(clk), .rst_n(rst_n), .warp_active(active),
        .slot0_word(s0), .slot1_word(s1),
        .ld_done_valid(ldv), .ld_done_warp(ldw), .ld_done_reg(ldr),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_dual(issue_dual),
        .warp_eligible(warp_eligible), .warp_done(warp_done)
    );

    // {active mask, expect issue, expect warp}; fresh destinations every row
    localparam logic [6:0] VEC [10] = '{
        7'b1111_1_00, 7'b1111_1_01, 7'b1010_1_11, 7'b1111_1_00, 7'b0000_0_00,
        7'b0100_1_10, 7'b0011_1_00, 7'b0001_1_00, 7'b1001_1_11, 7'b0110_1_01
    };

    function automatic logic [IW-1:0] mk(input logic [1:0] k, input int d, input int a, input int b);
        return {1'b1, k, d[3:0], a[3:0], b[3:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; active = '0; s0 = '0; s1 = '0; ldv = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        // table: rotating priority over changing active masks (R3, R9, R2)
        do_reset();
        for (int i = 0; i < 10; i++) begin
            active = VEC[i][6:3];
            for (int w = 0; w < W; w++) s0[w*IW +: IW] = mk(K_ALU, i % 16, (i + 8) % 16, (i + 8) % 16);
            s1 = '0;
            smp();
            chk("R3/R9 issue_valid", int'(issue_valid), int'(VEC[i][2]));
            if (VEC[i][2]) chk("R3 issue_warp", int'(issue_warp), int'(VEC[i][1:0]));
            chk("R2 eligible mask", int'(warp_eligible), int'(VEC[i][6:3]));
            tick();
        end

        // R1: reset state and first grant goes to warp 0
        do_reset();
        smp();
        chk("R1 idle issue", int'(issue_valid), 0);
        chk("R1 done clear", int'(warp_done), 0);
        tick();
        active = 4'b0101;
        s0[0*IW +: IW] = mk(K_ALU, 1, 2, 3);
        s0[2*IW +: IW] = mk(K_ALU, 1, 2, 3);
        smp();
        chk("R1 first grant", int'(issue_warp), 0);
        chk("R1 eligible", int'(warp_eligible), 5);
        tick();

        // R5: arithmetic dependency released after exactly six cycles
        do_reset();
        active = 4'b0001;
        s0[0 +: IW] = mk(K_ALU, 5, 0, 0);
        smp();
        chk("R5 producer issues", int'(issue_valid), 1);
        tick();
        s0[0 +: IW] = mk(K_ALU, 6, 5, 0);
        for (int k = 1; k <= 6; k++) begin
            smp();
            chk($sformatf("R5 dependant at c+%0d", k), int'(issue_valid), (k == 6) ? 1 : 0);
            if (k == 1) chk("R2 stalled warp not eligible", int'(warp_eligible[0]), 0);
            tick();
        end
        s0[0 +: IW] = mk(K_ALU, 6, 1, 1);
        smp();
        chk("R2 destination pending stalls", int'(issue_valid), 0);
        tick();

        // R4: pairing rules
        do_reset();
        active = 4'b0001;
        s0[0 +: IW] = mk(K_ALU, 1, 2, 3); s1[0 +: IW] = mk(K_ALU, 4, 5, 6);
        smp(); chk("R4 independent pair", int'(issue_dual), 1); tick();
        s0[0 +: IW] = mk(K_ALU, 7, 2, 3); s1[0 +: IW] = mk(K_ALU, 8, 7, 0);
        smp(); chk("R4 reads first dst", int'(issue_dual), 0);
        chk("R4 single still issues", int'(issue_valid), 1); tick();
        s0[0 +: IW] = mk(K_ALU, 9, 2, 3); s1[0 +: IW] = mk(K_ALU, 9, 0, 0);
        smp(); chk("R4 same dst", int'(issue_dual), 0); tick();
        s0[0 +: IW] = mk(K_ALU, 10, 0, 0); s1[0 +: IW] = mk(K_ALU, 11, 1, 0);
        smp(); chk("R4 second source pending", int'(issue_dual), 0); tick();
        s0[0 +: IW] = mk(K_ALU, 12, 0, 0); s1[0 +: IW] = mk(K_ALU, 13, 0, 0);
        smp(); chk("R4 pair again", int'(issue_dual), 1); tick();
        s0[0 +: IW] = mk(K_ALU, 14, 0, 0); s1[0 +: IW] = mk(K_EXIT, 0, 0, 0);
        smp(); chk("R4 exit never pairs", int'(issue_dual), 0); tick();
        s1 = '0;

        // R6 and R7: load latency hidden, stray completions ignored
        do_reset();
        active = 4'b0001;
        s0[0 +: IW] = mk(K_LD, 3, 0, 0);
        smp(); chk("R6 load issues", int'(issue_valid), 1); tick();
        s0[0 +: IW] = mk(K_ALU, 4, 1, 2);
        smp(); chk("R6 independent after load", int'(issue_valid), 1); tick();
        s0[0 +: IW] = mk(K_ALU, 5, 3, 0);
        for (int k = 0; k < 20; k++) begin
            smp();
            if (k == 0 || k == 19) chk("R6 dependant stalls", int'(issue_valid), 0);
            tick();
        end
        ldv = 1'b1; ldw = 2'd1; ldr = 4'd3; tick();
        ldw = 2'd0; ldr = 4'd7; tick();
        ldv = 1'b0;
        smp(); chk("R7 stray completion", int'(issue_valid), 0); tick();
        ldv = 1'b1; ldw = 2'd0; ldr = 4'd3;
        smp(); chk("R6 still stalled in completion cycle", int'(issue_valid), 0); tick();
        ldv = 1'b0;
        smp(); chk("R6 released after completion", int'(issue_valid), 1); tick();

        // R8: exit, drain and done
        do_reset();
        active = 4'b0001;
        s0[0 +: IW] = mk(K_LD, 2, 0, 0);
        smp(); chk("R8 load issues", int'(issue_valid), 1); tick();
        s0[0 +: IW] = mk(K_EXIT, 0, 0, 0); s1[0 +: IW] = mk(K_ALU, 5, 0, 0);
        smp(); chk("R8 exit issues", int'(issue_valid), 1);
        chk("R8 exit single", int'(issue_dual), 0); tick();
        s0[0 +: IW] = mk(K_ALU, 6, 0, 0); s1 = '0;
        for (int k = 0; k < 4; k++) begin
            smp();
            chk("R8 no issue after exit", int'(issue_valid), 0);
            chk("R8 done waits for load", int'(warp_done[0]), 0);
            tick();
        end
        ldv = 1'b1; ldw = 2'd0; ldr = 4'd2; tick();
        ldv = 1'b0;
        smp(); chk("R8 done after drain", int'(warp_done[0]), 1);
        chk("R8 still no issue", int'(issue_valid), 0); tick();
        active = 4'b0011;
        s0[1*IW +: IW] = mk(K_EXIT, 0, 0, 0);
        smp(); chk("R8 second warp exit", int'(issue_warp), 1); tick();
        smp(); chk("R8 done without pending", int'(warp_done), 3); tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule